// File: doc/BRIEF.md
# Framed SPI Register-Window Master

This block is an SPI master that reads or writes a burst of 16-bit words in a small window of eight device registers. A host raises a request carrying a direction, a byte address and a byte count. The master turns these into a 16-bit command word and shifts it out with the data burst inside a single chip-select frame. Write data is pulled from the host one word at a time over a valid/ready pair. Read data is handed back one word at a time over another valid/ready pair.

The serial clock runs in SPI mode 0. Its half period in system clock cycles comes from a configuration input. That value is clamped so the serial clock always stays between 1 MHz and 52 MHz. After each frame the chip select stays high for a guard interval before the next frame can start. A request with a byte count of zero completes at once without touching the bus.

Top module: `spi_regwin_master`

## Requirements
- R1: Bit 15 of the command word, the first bit on MOSI in a frame, is 1 for a read request and 0 for a write request.
- R2: Command bits 14:12 hold byte-address bits 4:2, so 0x14 gives index 5. Address bits 1:0 and bits 7:5 have no effect on the frame.
- R3: Command bits 11:0 hold the burst length in 16-bit words, equal to (byte count + 1) / 2. An odd byte count therefore moves one extra whole word.
- R4: One chip-select-low frame holds exactly 16 x (1 + words) rising SCLK edges: first the command word, then the data words with no break in chip select.
- R5: Every word is shifted MSB first, so bits 15:8 go out before bits 7:0. A write word arrives at the device equal to wr_data. A read word is assembled with the first MISO bit in bit 15.
- R6: SPI mode 0 is used. SCLK is low whenever cs_n is high, and there is no SCLK edge outside a frame. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge.
- R7: The SCLK high and low phases each last H system clocks, where H = cfg_div clamped to the range [2, 100]. With a 200 MHz system clock this keeps SCLK between 1 MHz and 50 MHz. H is captured when the request is accepted.
- R8: busy rises in the cycle after a non-empty request is accepted. It stays high until the guard interval after the frame has ended. Requests presented while busy is high are ignored and produce no frame.
- R9: A request with byte count 0 gives no chip-select or SCLK activity. done pulses for one cycle in the cycle after acceptance, and busy stays low.
- R10: done pulses for one cycle in the same cycle in which cs_n returns high. cs_n then stays high for at least 4 x H system clocks, which is two SCLK periods, before the next frame begins.
- R11: In a write, each data word is taken in a wr_valid/wr_ready handshake just before it is shifted, with SCLK held low while waiting. In a read, each word is held on rd_data with rd_valid high until rd_ready is seen. wr_ready and rd_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Requested SCLK half period in system clocks (clamped) |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_read | input | 1 | 1 = read burst, 0 = write burst |
| req_addr | input | 8 | Byte address; bits 4:2 select the register |
| req_bytes | input | 12 | Byte count of the burst |
| busy | output | 1 | A frame or its guard interval is in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_data | input | 16 | Write word offered by the host |
| wr_valid | input | 1 | wr_data is valid |
| wr_ready | output | 1 | Master takes wr_data this cycle if valid |
| rd_data | output | 16 | Received read word |
| rd_valid | output | 1 | rd_data holds an untaken word |
| rd_ready | input | 1 | Host takes rd_data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the device |

## Verification
The bench uses requests with odd byte counts, addresses whose ignored bits are set, and divider values below, inside and above the legal range. A length or rounding error shows up as a wrong bit count per frame and a wrong command word. A missing clamp shows up as an SCLK high phase of the wrong width. A request presented while busy must not start a second frame. A master that accepted it would record an extra frame. A zero-length request must give done with no frame, and back-to-back bursts must keep chip select high for the full guard time. Host stalls on both data handshakes are mixed in, so a master that shifted without waiting would deliver wrong words.

// File: rtl/spw_pkg.sv
package spw_pkg;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 3;
    localparam int LEN_W  = WORD_W - 1 - IDX_W;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_LOW     = 3'd1,
        PH_HIGH    = 3'd2,
        PH_WAIT_WR = 3'd3,
        PH_WAIT_RD = 3'd4,
        PH_TAIL    = 3'd5,
        PH_GUARD   = 3'd6
    } phase_e;
endpackage

// File: rtl/spw_half_clamp.sv
module spw_half_clamp #(
    parameter int CLK_HZ      = 200_000_000,
    parameter int SCLK_MAX_HZ = 52_000_000,
    parameter int SCLK_MIN_HZ = 1_000_000,
    parameter int DIV_W       = 8
) (
    input  logic [DIV_W-1:0] cfg_div,
    output logic [DIV_W-1:0] half
);
    // Shortest half period that keeps SCLK at or below the upper limit,
    // longest one that keeps it at or above the lower limit.
    localparam int HALF_MIN = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    localparam int HALF_MAX = CLK_HZ / (2 * SCLK_MIN_HZ);

    always_comb begin
        if (cfg_div < DIV_W'(HALF_MIN)) begin
            half = DIV_W'(HALF_MIN);
        end else if (cfg_div > DIV_W'(HALF_MAX)) begin
            half = DIV_W'(HALF_MAX);
        end else begin
            half = cfg_div;
        end
    end
endmodule

// File: rtl/spw_header_enc.sv
module spw_header_enc #(
    parameter int ADDR_W  = 8,
    parameter int BYTES_W = 12
) (
    input  logic                        read,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTES_W-1:0]          bytes,
    output logic [spw_pkg::WORD_W-1:0]  header,
    output logic [spw_pkg::LEN_W-1:0]   words,
    output logic                        empty
);
    logic [BYTES_W:0] rounded;
    logic             unused_addr_bits;

    // Round odd byte counts up to whole 16-bit words.
    assign rounded = {1'b0, bytes} + (BYTES_W + 1)'(1);
    assign words   = spw_pkg::LEN_W'(rounded >> 1);
    assign empty   = (bytes == '0);
    assign header  = {read, addr[4:2], words};

    assign unused_addr_bits = ^{addr[ADDR_W-1:5], addr[1:0]};
endmodule

// File: rtl/spi_regwin_master.sv
module spi_regwin_master #(
    parameter int CLK_HZ      = 200_000_000,
    parameter int SCLK_MAX_HZ = 52_000_000,
    parameter int SCLK_MIN_HZ = 1_000_000,
    parameter int DIV_W       = 8,
    parameter int ADDR_W      = 8,
    parameter int BYTES_W     = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIV_W-1:0]           cfg_div,
    input  logic                       req_valid,
    input  logic                       req_read,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [BYTES_W-1:0]         req_bytes,
    output logic                       busy,
    output logic                       done,
    input  logic [spw_pkg::WORD_W-1:0] wr_data,
    input  logic                       wr_valid,
    output logic                       wr_ready,
    output logic [spw_pkg::WORD_W-1:0] rd_data,
    output logic                       rd_valid,
    input  logic                       rd_ready,
    output logic                       sclk,
    output logic                       mosi,
    output logic                       cs_n,
    input  logic                       miso
);
    import spw_pkg::*;

    localparam int CNT_W = DIV_W + 2;
    localparam int BIT_W = $clog2(WORD_W);

    typedef struct packed {
        phase_e             st;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   bitn;
        logic [WORD_W-1:0]  sh;
        logic [WORD_W-1:0]  rx;
        logic [WORD_W-1:0]  rdat;
        logic [LEN_W-1:0]   left;
        logic [DIV_W-1:0]   half;
        logic               hdr;
        logic               rd;
        logic               sclk;
        logic               cs_n;
        logic               done;
        logic               rvld;
    } regs_t;

    regs_t q, d;

    logic [DIV_W-1:0]  half_req;
    logic [WORD_W-1:0] hdr_word;
    logic [LEN_W-1:0]  hdr_len;
    logic              req_empty;
    logic [CNT_W-1:0]  half_m1;
    logic [CNT_W-1:0]  guard_m1;

    spw_half_clamp #(
        .CLK_HZ      (CLK_HZ),
        .SCLK_MAX_HZ (SCLK_MAX_HZ),
        .SCLK_MIN_HZ (SCLK_MIN_HZ),
        .DIV_W       (DIV_W)
    ) i_clamp (
        .cfg_div (cfg_div),
        .half    (half_req)
    );

    spw_header_enc #(
        .ADDR_W  (ADDR_W),
        .BYTES_W (BYTES_W)
    ) i_enc (
        .read   (req_read),
        .addr   (req_addr),
        .bytes  (req_bytes),
        .header (hdr_word),
        .words  (hdr_len),
        .empty  (req_empty)
    );

    assign half_m1  = CNT_W'(q.half) - CNT_W'(1);
    assign guard_m1 = (CNT_W'(q.half) << 2) - CNT_W'(1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_empty) begin
                        d.done = 1'b1;
                    end else begin
                        d.st   = PH_LOW;
                        d.cs_n = 1'b0;
                        d.sh   = hdr_word;
                        d.left = hdr_len;
                        d.hdr  = 1'b1;
                        d.rd   = req_read;
                        d.bitn = BIT_W'(WORD_W - 1);
                        d.half = half_req;
                        d.cnt  = CNT_W'(half_req) - CNT_W'(1);
                    end
                end
            end
            PH_LOW: begin
                if (q.cnt == '0) begin
                    d.sclk = 1'b1;
                    d.rx   = {q.rx[WORD_W-2:0], miso};
                    d.st   = PH_HIGH;
                    d.cnt  = half_m1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            PH_HIGH: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else begin
                    d.sclk = 1'b0;
                    d.cnt  = half_m1;
                    if (q.bitn != '0) begin
                        d.bitn = q.bitn - BIT_W'(1);
                        d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                        d.st   = PH_LOW;
                    end else begin
                        d.hdr = 1'b0;
                        d.sh  = '0;
                        if (q.rd && !q.hdr) begin
                            d.rdat = q.rx;
                            d.rvld = 1'b1;
                            d.st   = PH_WAIT_RD;
                        end else if (q.left == '0) begin
                            d.st = PH_TAIL;
                        end else if (q.rd) begin
                            d.left = q.left - LEN_W'(1);
                            d.bitn = BIT_W'(WORD_W - 1);
                            d.st   = PH_LOW;
                        end else begin
                            d.st = PH_WAIT_WR;
                        end
                    end
                end
            end
            PH_WAIT_WR: begin
                if (wr_valid) begin
                    d.sh   = wr_data;
                    d.left = q.left - LEN_W'(1);
                    d.bitn = BIT_W'(WORD_W - 1);
                    d.st   = PH_LOW;
                    d.cnt  = half_m1;
                end
            end
            PH_WAIT_RD: begin
                if (rd_ready) begin
                    d.rvld = 1'b0;
                    d.cnt  = half_m1;
                    if (q.left == '0) begin
                        d.st = PH_TAIL;
                    end else begin
                        d.left = q.left - LEN_W'(1);
                        d.bitn = BIT_W'(WORD_W - 1);
                        d.st   = PH_LOW;
                    end
                end
            end
            PH_TAIL: begin
                if (q.cnt == '0) begin
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                    d.st   = PH_GUARD;
                    d.cnt  = guard_m1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            PH_GUARD: begin
                if (q.cnt == '0) begin
                    d.st = PH_IDLE;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != PH_IDLE);
    assign done     = q.done;
    assign wr_ready = (q.st == PH_WAIT_WR);
    assign rd_data  = q.rdat;
    assign rd_valid = q.rvld;
    assign sclk     = q.sclk;
    assign mosi     = q.sh[WORD_W-1];
    assign cs_n     = q.cs_n;

    // R6: clock parked low outside a frame
    a_r6_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> !q.sclk);

    // R6: MOSI does not move on the rising SCLK edge
    a_r6_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sclk) |-> $stable(q.sh[WORD_W-1]));

    // R8: an open frame always shows busy
    a_r8_frame_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cs_n |-> busy);

    // R10: completion of a real burst coincides with chip select rising
    a_r10_done_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && busy) |-> $rose(q.cs_n));

    // R9: empty request finishes without a frame
    a_r9_empty_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !busy) |-> (q.cs_n && !q.sclk));

    // R11: the two data handshakes never overlap
    a_r11_handshake_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ready && rd_valid));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: tb/test_spi_regwin_master.sv
`timescale 1ns/1ps
module test_spi_regwin_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd4;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [7:0]  req_addr = 8'h00;
    logic [11:0] req_bytes = 12'd0;
    logic        busy, done, wr_ready, rd_valid, sclk, mosi, cs_n;
    logic [15:0] wr_data, rd_data;
    logic        wr_valid, rd_ready;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_regwin_master i_spi_regwin_master (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
        .req_bytes(req_bytes), .busy(busy), .done(done),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );

    int errors = 0;
    int checks = 0;

    function automatic logic [15:0] wr_pat(int k);
        return 16'(k * 40503) ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] rd_pat(int k);
        return 16'(k * 3371) ^ 16'hB4C3;
    endfunction

    // Host side: stalls on both handshakes follow a free-running count.
    int cyc = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [15:0] rd_got [0:15];
    assign wr_valid = (cyc % 8 != 1) && (cyc % 8 != 5);
    assign rd_ready = (cyc % 4 != 2);
    assign wr_data  = wr_pat(wr_cnt);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_valid && wr_ready) wr_cnt <= wr_cnt + 1;
        if (rd_valid && rd_ready) begin
            rd_got[rd_cnt % 16] <= rd_data;
            rd_cnt <= rd_cnt + 1;
        end
    end

    // Device model on the serial side.
    int          frames = 0;
    int          nbits = 0;
    int          spur = 0;
    logic [15:0] cap_sh = 16'h0;
    logic [15:0] cap_w [0:15];
    realtime     t_rise = 0.0;
    realtime     hi_w = 0.0;
    realtime     t_csup = 0.0;
    realtime     gap = 0.0;

    function automatic logic miso_bit(int n);
        int w;
        logic [15:0] v;
        w = n / 16;
        if (w == 0) return 1'b0;
        v = rd_pat(w);
        return v[15 - (n % 16)];
    endfunction

    always @(negedge cs_n) begin
        frames = frames + 1;
        nbits = 0;
        gap = $realtime - t_csup;
        miso = miso_bit(0);
    end

    always @(posedge cs_n) t_csup = $realtime;

    always @(posedge sclk) begin
        if (cs_n) spur = spur + 1;
        t_rise = $realtime;
        cap_sh = {cap_sh[14:0], mosi};
        nbits = nbits + 1;
        if (nbits % 16 == 0) begin
            int k;
            k = nbits / 16 - 1;
            if (k < 16) cap_w[k] = cap_sh;
        end
    end

    always @(negedge sclk) begin
        hi_w = $realtime - t_rise;
        miso = miso_bit(nbits);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int clamp_half(logic [7:0] dv);
        if (dv < 8'd2) return 2;
        if (dv > 8'd100) return 100;
        return int'(dv);
    endfunction

    // Vector table: {read, addr, bytes, cfg_div}
    localparam int NVEC = 6;
    localparam logic [28:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'h14, 12'd4,  8'd3},
        {1'b1, 8'h0B, 12'd6,  8'd2},
        {1'b0, 8'hFF, 12'd3,  8'd0},
        {1'b1, 8'h00, 12'd1,  8'd255},
        {1'b0, 8'h1C, 12'd10, 8'd5},
        {1'b1, 8'h04, 12'd2,  8'd1}
    };

    int prev_half = 0;

    task automatic run_vec(input int vi, input logic rd, input logic [7:0] ad,
                           input logic [11:0] nb, input logic [7:0] dv);
        int words, half, f0, wb, rb, n;
        logic [15:0] exp_hdr;
        words = (int'(nb) + 1) / 2;
        half = clamp_half(dv);
        exp_hdr = {rd, ad[4:2], 12'(words)};
        @(negedge clk);
        cfg_div = dv; req_read = rd; req_addr = ad; req_bytes = nb; req_valid = 1'b1;
        f0 = frames; wb = wr_cnt; rb = rd_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
        // Request while busy: must leave no trace.
        req_valid = 1'b1; req_read = ~rd; req_addr = 8'h18; req_bytes = 12'd8; cfg_div = 8'd7;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (done !== 1'b1 && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk(cs_n === 1'b1 && busy === 1'b1, "R10 done with cs_n high", {cs_n, busy}, 32'b11);
        n = 0;
        while (busy === 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(frames == f0 + 1, "R8 one frame per accepted request", 32'(frames - f0), 32'd1);
        chk(cap_w[0] == exp_hdr, "R1 R2 R3 command word", 32'(cap_w[0]), 32'(exp_hdr));
        chk(nbits == 16 * (words + 1), "R4 bits in frame", 32'(nbits), 32'(16 * (words + 1)));
        chk(hi_w > real'(half) * 5.0 - 0.01 && hi_w < real'(half) * 5.0 + 0.01,
            "R7 SCLK high phase", 32'(int'(hi_w * 10.0)), 32'(half * 50));
        chk(spur == 0, "R6 no SCLK edge outside frame", 32'(spur), 32'd0);
        if (rd) begin
            chk(rd_cnt - rb == words, "R11 read words handed over", 32'(rd_cnt - rb), 32'(words));
            for (int k = 0; k < words; k++)
                chk(rd_got[(rb + k) % 16] == rd_pat(k + 1), "R5 read word order",
                    32'(rd_got[(rb + k) % 16]), 32'(rd_pat(k + 1)));
        end else begin
            chk(wr_cnt - wb == words, "R11 write words taken", 32'(wr_cnt - wb), 32'(words));
            for (int k = 1; k <= words; k++)
                chk(cap_w[k] == wr_pat(wb + k - 1), "R5 write word on wire",
                    32'(cap_w[k]), 32'(wr_pat(wb + k - 1)));
        end
        if (vi > 0)
            chk(gap >= real'(prev_half) * 20.0 - 0.01, "R10 guard between frames",
                32'(int'(gap)), 32'(prev_half * 20));
        prev_half = half;
    endtask

    initial begin
        #900000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // Reset state
        chk(cs_n === 1'b1 && sclk === 1'b0, "R6 reset idle lines", {cs_n, sclk}, 32'b10);
        chk(busy === 1'b0 && done === 1'b0, "R8 reset busy/done", {busy, done}, 32'b00);
        chk(wr_ready === 1'b0 && rd_valid === 1'b0, "R11 reset handshakes", {wr_ready, rd_valid}, 32'b00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++)
            run_vec(i, VEC[i][28], VEC[i][27:20], VEC[i][19:8], VEC[i][7:0]);

        // R9: zero-length request
        begin
            int f0;
            f0 = frames;
            @(negedge clk);
            req_read = 1'b1; req_addr = 8'h08; req_bytes = 12'd0; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(done === 1'b1, "R9 done one cycle after empty request", 32'(done), 32'd1);
            chk(busy === 1'b0 && cs_n === 1'b1, "R9 no busy, no chip select", {busy, cs_n}, 32'b01);
            @(negedge clk);
            chk(done === 1'b0, "R9 done is one cycle", 32'(done), 32'd0);
            repeat (10) @(negedge clk);
            chk(frames == f0 && spur == 0, "R9 no frame for empty request", 32'(frames - f0), 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule